// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a 32-bit processor in which each instruction takes several clock cycles. It steps through a fixed set of numbered phases, one per cycle, and drives the datapath's select lines, write enables and ALU operation class for the current phase. Every output is a flop whose value depends only on the phase it belongs to, so the datapath never sees a control line react to the instruction bits within a cycle.

The datapath keeps the fetched instruction in its instruction register and presents the 6-bit opcode and 6-bit function field to this block. The block looks at them only when it chooses the next phase, in decode, and, for memory instructions, in the address phase. It handles word load, word store, register-register ALU operations, branch-on-equal, jump, jump-and-link, and an indexed load. The indexed load is encoded as an R-type instruction that uses a spare function code. It adds two registers to form an address, reads that memory word, and writes the word to the rt register. The current phase number is also visible at the ports.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the phase to 0 (fetch) on the next clock edge and holds it there, with the fetch control values, for as long as it stays high. This holds even in the middle of an instruction.
- R2: Phase 0 always moves to phase 1. In phase 0 the controls are `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `addr_sel`=0, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add), `pc_src`=00, and every other output is 0.
- R3: In phase 1 (decode) the only nonzero controls are `alu_b_sel`=11 (shifted immediate). `alu_a_sel`=0 and `alu_op`=00. The next phase depends on the opcode: 0x23 or 0x2B goes to 2, 0x00 goes to 6 (or to 11, see R10), 0x04 goes to 8, 0x02 goes to 9 and 0x03 goes to 10.
- R4: A load (opcode 0x23) runs the phases 0,1,2,3,4,0 and so takes 5 cycles. Phase 2 has `alu_a_sel`=1 and `alu_b_sel`=10 (immediate). Phase 3 has `mem_rd`=1 and `addr_sel`=1. Phase 4 has `reg_wr`=1, `dst_sel`=00 (rt) and `wb_sel`=01 (memory data).
- R5: A store (opcode 0x2B) runs the phases 0,1,2,5,0 and so takes 4 cycles. Phase 5 has `mem_wr`=1 and `addr_sel`=1.
- R6: An R-type instruction (opcode 0x00, any function code except 0x05) runs the phases 0,1,6,7,0. Phase 6 has `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (use the function field). Phase 7 has `reg_wr`=1, `dst_sel`=01 (rd) and `wb_sel`=00 (ALU result).
- R7: A branch-on-equal runs the phases 0,1,8,0. Phase 8 has `pc_wr_cond`=1, `pc_src`=01 (the stored ALU result), `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01 (subtract).
- R8: A jump runs the phases 0,1,9,0. Phase 9 has `pc_wr`=1 and `pc_src`=10 (jump target).
- R9: A jump-and-link runs the phases 0,1,10,0. In phase 10 the block writes the PC and a register in the same cycle: `pc_wr`=1, `pc_src`=10, `reg_wr`=1, `dst_sel`=10 (register 31) and `wb_sel`=10 (PC value).
- R10: Opcode 0x00 with function code 0x05 is the indexed load. It runs the phases 0,1,11,12,13,0. Phase 11 has `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=00. Phase 12 has `mem_rd`=1 and `addr_sel`=1. Phase 13 has `reg_wr`=1, `dst_sel`=00 and `wb_sel`=01. Function code 0x05 under any other opcode has no effect.
- R11: An opcode that R3 does not list returns to phase 0 directly after phase 1.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| funct | input | 6 | Function field of the held instruction |
| phase | output | 4 | Current phase number |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU reports equality |
| pc_src | output | 2 | PC source: 00 ALU, 01 stored ALU result, 10 jump target |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 stored ALU result |
| ir_wr | output | 1 | Instruction register write |
| dst_sel | output | 2 | Destination register: 00 rt, 01 rd, 10 register 31 |
| wb_sel | output | 2 | Write data: 00 ALU result, 01 memory data, 10 PC |
| reg_wr | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |

## Verification
The one phase in which two architectural updates fall together is the jump-and-link completion. There the PC is reloaded from the jump target and register 31 is written with the PC value in the same cycle. The bench reaches that phase with opcode 0x03, placed directly after other instructions and directly before them. In that cycle its model expects both write enables together with all three select codes at value 10, and it expects the next instruction's fetch to follow on the very next cycle.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm #(
  parameter int OP_W = 6,
  parameter int ST_W = 4,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_LW    = 6'h23,
  parameter logic [OP_W-1:0] OP_SW    = 6'h2B,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_J     = 6'h02,
  parameter logic [OP_W-1:0] OP_JAL   = 6'h03,
  parameter logic [OP_W-1:0] FN_LDX   = 6'h05
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [OP_W-1:0] funct,
  output logic [ST_W-1:0] phase,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic [1:0]      pc_src,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            addr_sel,
  output logic            ir_wr,
  output logic [1:0]      dst_sel,
  output logic [1:0]      wb_sel,
  output logic            reg_wr,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic [1:0]      alu_op
);
  localparam int CTL_W = 18;
  localparam logic [ST_W-1:0] S_FETCH = 4'd0,  S_DEC   = 4'd1,  S_MADDR = 4'd2,
                              S_MRD   = 4'd3,  S_LDWB  = 4'd4,  S_MWR   = 4'd5,
                              S_EXE   = 4'd6,  S_RDONE = 4'd7,  S_BR    = 4'd8,
                              S_JMP   = 4'd9,  S_JAL   = 4'd10, S_XADDR = 4'd11,
                              S_XRD   = 4'd12, S_XWB   = 4'd13;

  logic [ST_W-1:0]  state, nxt;
  logic [CTL_W-1:0] ctl;

  // field order: pc_wr pc_wr_cond pc_src mem_rd mem_wr addr_sel ir_wr
  //              dst_sel wb_sel reg_wr alu_a_sel alu_b_sel alu_op
  function automatic logic [CTL_W-1:0] ctl_of(input logic [ST_W-1:0] s);
    case (s)
      S_FETCH: ctl_of = {1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b01, 2'b00};
      S_DEC:   ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b11, 2'b00};
      S_MADDR: ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 2'b10, 2'b00};
      S_MRD,
      S_XRD:   ctl_of = {1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00};
      S_LDWB,
      S_XWB:   ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 2'b00, 2'b00};
      S_MWR:   ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00};
      S_EXE:   ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b10};
      S_RDONE: ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 2'b00, 2'b00};
      S_BR:    ctl_of = {1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b01};
      S_JMP:   ctl_of = {1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00};
      S_JAL:   ctl_of = {1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 2'b10, 1'b1, 1'b0, 2'b00, 2'b00};
      S_XADDR: ctl_of = {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'b00};
      default: ctl_of = '0;
    endcase
  endfunction

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH: nxt = S_DEC;
      S_DEC: begin
        if (opcode == OP_LW || opcode == OP_SW) nxt = S_MADDR;
        else if (opcode == OP_RTYPE)            nxt = (funct == FN_LDX) ? S_XADDR : S_EXE;
        else if (opcode == OP_BEQ)              nxt = S_BR;
        else if (opcode == OP_J)                nxt = S_JMP;
        else if (opcode == OP_JAL)              nxt = S_JAL;
        else                                    nxt = S_FETCH;
      end
      S_MADDR: nxt = (opcode == OP_SW) ? S_MWR : S_MRD;
      S_MRD:   nxt = S_LDWB;
      S_EXE:   nxt = S_RDONE;
      S_XADDR: nxt = S_XRD;
      S_XRD:   nxt = S_XWB;
      default: nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      ctl   <= ctl_of(S_FETCH);
    end else begin
      state <= nxt;
      ctl   <= ctl_of(nxt);
    end
  end

  assign phase = state;
  assign {pc_wr, pc_wr_cond, pc_src, mem_rd, mem_wr, addr_sel, ir_wr,
          dst_sel, wb_sel, reg_wr, alu_a_sel, alu_b_sel, alu_op} = ctl;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] phase,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic [1:0] pc_src,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic [1:0] dst_sel,
  input logic [1:0] wb_sel,
  input logic       reg_wr
);
  p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_fetch_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd0) |-> (pc_wr && ir_wr && mem_rd && !reg_wr));

  p_fetch_to_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd0) |=> (phase == 4'd1));

  p_load_read_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd3) |=> (phase == 4'd4));

  p_jal_both_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd10) |-> (pc_wr && reg_wr && pc_src == 2'b10 &&
                          dst_sel == 2'b10 && wb_sel == 2'b10));

  p_jal_return_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd10) |=> (phase == 4'd0));

  p_branch_cond_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd8) |-> (pc_wr_cond && !pc_wr && pc_src == 2'b01));

  p_ldx_chain_r10: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd11) |=> (phase == 4'd12));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .rst(rst), .phase(phase), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .pc_src(pc_src), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
  .dst_sel(dst_sel), .wb_sel(wb_sel), .reg_wr(reg_wr)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] opcode = 6'h00, funct = 6'h00;
  logic [3:0] phase;
  logic pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, ir_wr, reg_wr, alu_a_sel;
  logic [1:0] pc_src, dst_sel, wb_sel, alu_b_sel, alu_op;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_ctrl_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .phase(phase),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr), .dst_sel(dst_sel),
    .wb_sel(wb_sel), .reg_wr(reg_wr), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );

  // Expected controls per phase, taken field by field from the requirements.
  function automatic logic [17:0] want(input int s);
    logic pw = 0, pwc = 0, mr = 0, mw = 0, as = 0, iw = 0, rw = 0, aa = 0;
    logic [1:0] ps = 0, ds = 0, ws = 0, ab = 0, op = 0;
    case (s)
      0:  begin pw = 1; mr = 1; iw = 1; ab = 2'b01; end        // R2
      1:  ab = 2'b11;                                           // R3
      2:  begin aa = 1; ab = 2'b10; end                         // R4
      3, 12: begin mr = 1; as = 1; end                          // R4 R10
      4, 13: begin rw = 1; ws = 2'b01; end                      // R4 R10
      5:  begin mw = 1; as = 1; end                             // R5
      6:  begin aa = 1; op = 2'b10; end                         // R6
      7:  begin rw = 1; ds = 2'b01; end                         // R6
      8:  begin pwc = 1; ps = 2'b01; aa = 1; op = 2'b01; end    // R7
      9:  begin pw = 1; ps = 2'b10; end                         // R8
      10: begin pw = 1; ps = 2'b10; rw = 1; ds = 2'b10; ws = 2'b10; end // R9
      11: aa = 1;                                               // R10
      default: ;
    endcase
    return {pw, pwc, ps, mr, mw, as, iw, ds, ws, rw, aa, ab, op};
  endfunction

  function automatic logic [17:0] got();
    return {pc_wr, pc_wr_cond, pc_src, mem_rd, mem_wr, addr_sel, ir_wr,
            dst_sel, wb_sel, reg_wr, alu_a_sel, alu_b_sel, alu_op};
  endfunction

  task automatic check(input int s, input string tag);
    n_run++;
    if (phase !== 4'(s) || got() !== want(s)) begin
      n_fail++;
      $display("FAIL %s: phase=%0d ctl=%h expected phase=%0d ctl=%h",
               tag, phase, got(), s, want(s));
    end
    n_run++;
    if (mem_rd && mem_wr) begin
      n_fail++;
      $display("FAIL R12: mem_rd=%b mem_wr=%b expected not both", mem_rd, mem_wr);
    end
  endtask

  // Reference sequence of phases for one instruction, per R3..R11.
  task automatic run(input logic [5:0] op, input logic [5:0] fn, input string tag);
    int seq[$];
    seq = {0, 1};
    if (op == 6'h23)      seq = {seq, 2, 3, 4};
    else if (op == 6'h2B) seq = {seq, 2, 5};
    else if (op == 6'h00) seq = (fn == 6'h05) ? {seq, 11, 12, 13} : {seq, 6, 7};
    else if (op == 6'h04) seq.push_back(8);
    else if (op == 6'h02) seq.push_back(9);
    else if (op == 6'h03) seq.push_back(10);
    opcode = op; funct = fn;
    foreach (seq[i]) begin
      check(seq[i], (i == 0) ? "R2" : (i == 1) ? "R3" : tag);
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, "R1");                // reset state
    rst = 1'b0;
    run(6'h23, 6'h00, "R4");
    run(6'h2B, 6'h00, "R5");
    run(6'h00, 6'h20, "R6");
    run(6'h00, 6'h22, "R6");
    run(6'h04, 6'h00, "R7");
    run(6'h02, 6'h00, "R8");
    run(6'h03, 6'h00, "R9");       // JAL: PC write and register write together
    run(6'h00, 6'h05, "R10");
    run(6'h23, 6'h05, "R10");      // spare funct under LW: plain load
    run(6'h03, 6'h00, "R9");
    run(6'h03, 6'h00, "R9");       // back to back
    run(6'h3F, 6'h00, "R11");
    run(6'h11, 6'h05, "R11");
    run(6'h2B, 6'h00, "R5");
    // R1: reset in the middle of a load
    opcode = 6'h23;
    check(0, "R2"); @(negedge clk);
    check(1, "R3"); @(negedge clk);
    check(2, "R4"); rst = 1'b1; @(negedge clk);
    check(0, "R1"); @(negedge clk);
    check(0, "R1"); rst = 1'b0;
    @(negedge clk);
    check(1, "R1");
    @(negedge clk);
    check(2, "R4");
    @(negedge clk);
    check(3, "R4");
    @(negedge clk);
    check(4, "R4");
    @(negedge clk);
    run(6'h00, 6'h05, "R10");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule